// File: doc/BRIEF.md
# Iterative 64-bit Substitution-Permutation Encryption Core

This core encrypts one 64-bit block under a 128-bit key. It runs one cipher round per clock. Each round XORs the upper half of a 128-bit key register into the state. It then passes every nibble of the state through a fixed 4-bit substitution box and scatters the bits with a fixed permutation.

While the rounds run, the key register steps forward in place on every clock. No round keys are stored. After the last round, one more key XOR produces the ciphertext. A one-cycle completion pulse marks the ciphertext as valid.

The controller is a three-state machine:
- **ST_IDLE** waits for `start`. On `start` it latches the plaintext and key and moves to ST_ROUND with the round number set to 1 (transition *accept*).
- **ST_ROUND** performs a round on every clock. It stays in ST_ROUND while the round number is below 31 (transition *iterate*). It moves to ST_FINAL after round 31 (transition *last round*).
- **ST_FINAL** forms the ciphertext, raises `done` and always returns to ST_IDLE (transition *retire*).

Top module: `spn_cipher_core`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `done` is 0 and `ciphertext` is all zeros.
- R2: The ciphertext is produced as follows. Load state = plaintext and K = key. Run 31 rounds, each doing: state ^= K[127:64]; apply the S-box to all 16 nibbles; apply the bit permutation; update K. Finally output state ^ K[127:64].
- R3: The S-box maps input values 0..F to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2 in that order.
- R4: The permutation sends state bit i to bit (16*i) mod 63 for i = 0..62, and bit 63 stays at bit 63.
- R5: The key update for round r (r = 1..31) runs in three steps:
  - rotate K left by 61 bits;
  - replace nibbles K[127:124] and K[123:120] with their S-box images;
  - XOR r into K[66:62].
- R6: If `start` is sampled high at rising edge n while the core is idle, `done` is high for exactly the one cycle after edge n+32 and low in the cycles either side of it.
- R7: A `start` sampled while a block is in progress is ignored. This includes the edge that retires the block. The running block's result and timing are unchanged, and no extra `done` pulse follows.
- R8: `ciphertext` keeps its value from one completion until the next.
- R9: `plaintext` and `key` are sampled only at the accepting edge. Changing them mid-run does not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin encrypting when idle |
| plaintext | input | 64 | Block to encrypt, sampled at accept |
| key | input | 128 | Cipher key, sampled at accept |
| ciphertext | output | 64 | Result of the last completed block |
| done | output | 1 | One-cycle pulse when `ciphertext` is new |

## Verification
The main function is exercised with several kinds of operands:
- all-zero and all-one operands in every combination, which show whether the constant round-number injection and the S-box image of 0 and F are wired correctly;
- keys that differ only in their low bits, which reach the state only after several rotations and so expose errors in the rotation amount and in the position of the round-number XOR;
- single-bit plaintexts, which trace the permutation wiring;
- pseudo-random operands, which cover the full S-box.

Control-path patterns cover the rest: a second `start` mid-run, a `start` on the retiring edge, a back-to-back `start` on the first idle cycle, and operands that change during a run. Together they separate correct acceptance from a core that restarts, double-pulses or samples its inputs late.

// File: rtl/spn_pkg.sv
package spn_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ROUND = 2'd1,
        ST_FINAL = 2'd2
    } fsm_t;

    localparam int NIB_W = 4;

    // 4-bit nonlinear substitution
    function automatic logic [NIB_W-1:0] sbox4(input logic [NIB_W-1:0] x);
        logic [NIB_W-1:0] y;
        unique case (x)
            4'h0: y = 4'hC;
            4'h1: y = 4'h5;
            4'h2: y = 4'h6;
            4'h3: y = 4'hB;
            4'h4: y = 4'h9;
            4'h5: y = 4'h0;
            4'h6: y = 4'hA;
            4'h7: y = 4'hD;
            4'h8: y = 4'h3;
            4'h9: y = 4'hE;
            4'hA: y = 4'hF;
            4'hB: y = 4'h8;
            4'hC: y = 4'h4;
            4'hD: y = 4'h7;
            4'hE: y = 4'h1;
            4'hF: y = 4'h2;
        endcase
        return y;
    endfunction

endpackage

// File: rtl/spn_sub_layer.sv
module spn_sub_layer
    import spn_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int NIBS = WIDTH / NIB_W;

    for (genvar n = 0; n < NIBS; n++) begin : g_nib
        assign dout[n*NIB_W +: NIB_W] = sbox4(din[n*NIB_W +: NIB_W]);
    end

endmodule

// File: rtl/spn_bit_perm.sv
module spn_bit_perm #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int STRIDE = WIDTH / 4;

    // pure rewiring: bit i lands at (STRIDE*i) mod (WIDTH-1), top bit fixed
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam int DST = (i == WIDTH-1) ? i : (i * STRIDE) % (WIDTH-1);
        assign dout[DST] = din[i];
    end

endmodule

// File: rtl/spn_key_step.sv
module spn_key_step
    import spn_pkg::*;
#(
    parameter int KEY_W  = 128,
    parameter int CNT_W  = 5,
    parameter int ROT    = 61,
    parameter int XOR_LO = 62
) (
    input  logic [KEY_W-1:0] kin,
    input  logic [CNT_W-1:0] rnd,
    output logic [KEY_W-1:0] kout
);
    logic [KEY_W-1:0] rot;

    always_comb begin
        rot  = {kin[KEY_W-1-ROT:0], kin[KEY_W-1:KEY_W-ROT]};
        kout = rot;
        kout[KEY_W-1 -: NIB_W]       = sbox4(rot[KEY_W-1 -: NIB_W]);
        kout[KEY_W-1-NIB_W -: NIB_W] = sbox4(rot[KEY_W-1-NIB_W -: NIB_W]);
        kout[XOR_LO +: CNT_W]        = rot[XOR_LO +: CNT_W] ^ rnd;
    end

endmodule

// File: rtl/spn_cipher_core.sv
module spn_cipher_core
    import spn_pkg::*;
#(
    parameter int BLOCK_W = 64,
    parameter int KEY_W   = 128,
    parameter int ROUNDS  = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [BLOCK_W-1:0] plaintext,
    input  logic [KEY_W-1:0]   key,
    output logic [BLOCK_W-1:0] ciphertext,
    output logic               done
);
    localparam int CNT_W = $clog2(ROUNDS + 1);
    localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(ROUNDS);
    localparam logic [CNT_W-1:0] FIRST_RND = CNT_W'(1);

    fsm_t               fsm_q, fsm_d;
    logic [BLOCK_W-1:0] state_q;
    logic [KEY_W-1:0]   key_q;
    logic [CNT_W-1:0]   rnd_q;
    logic [BLOCK_W-1:0] ct_q;
    logic               done_q;

    logic [BLOCK_W-1:0] round_key;
    logic [BLOCK_W-1:0] mixed;
    logic [BLOCK_W-1:0] subbed;
    logic [BLOCK_W-1:0] permuted;
    logic [KEY_W-1:0]   key_nxt;

    assign round_key = key_q[KEY_W-1 -: BLOCK_W];
    assign mixed     = state_q ^ round_key;

    spn_sub_layer #(.WIDTH(BLOCK_W)) u_sub (
        .din  (mixed),
        .dout (subbed)
    );

    spn_bit_perm #(.WIDTH(BLOCK_W)) u_perm (
        .din  (subbed),
        .dout (permuted)
    );

    spn_key_step #(.KEY_W(KEY_W), .CNT_W(CNT_W)) u_kstep (
        .kin  (key_q),
        .rnd  (rnd_q),
        .kout (key_nxt)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= ST_IDLE;
        else        fsm_q <= fsm_d;
    end

    // next-state logic
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            ST_IDLE:  if (start) fsm_d = ST_ROUND;
            ST_ROUND: if (rnd_q == LAST_RND) fsm_d = ST_FINAL;
            ST_FINAL: fsm_d = ST_IDLE;
            default:  fsm_d = ST_IDLE;
        endcase
    end

    // round datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
            key_q   <= '0;
            rnd_q   <= '0;
        end else begin
            unique case (fsm_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= plaintext;
                        key_q   <= key;
                        rnd_q   <= FIRST_RND;
                    end
                end
                ST_ROUND: begin
                    state_q <= permuted;
                    key_q   <= key_nxt;
                    rnd_q   <= rnd_q + FIRST_RND;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (fsm_q == ST_FINAL);
            if (fsm_q == ST_FINAL) ct_q <= mixed;
        end
    end

    assign ciphertext = ct_q;
    assign done       = done_q;

endmodule

// File: rtl/spn_cipher_core_chk.sv
module spn_cipher_core_chk
    import spn_pkg::*;
#(
    parameter int BLOCK_W = 64,
    parameter int KEY_W   = 128,
    parameter int ROUNDS  = 31,
    parameter int CNT_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               done,
    input logic [BLOCK_W-1:0] plaintext,
    input logic [KEY_W-1:0]   key,
    input logic [BLOCK_W-1:0] ciphertext,
    input fsm_t               fsm_q,
    input logic [CNT_W-1:0]   rnd_q,
    input logic [KEY_W-1:0]   key_q,
    input logic [BLOCK_W-1:0] state_q
);
    localparam int LW = $clog2(ROUNDS + 4) + 1;
    localparam logic [LW-1:0] LAT  = LW'(ROUNDS + 1);
    localparam logic [LW-1:0] SAT  = {LW{1'b1}};

    logic [LW-1:0] since_accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           since_accept <= SAT;
        else if (fsm_q == ST_IDLE && start)   since_accept <= '0;
        else if (since_accept != SAT)         since_accept <= since_accept + 1'b1;
    end

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> since_accept == LAT);

    a_r7_busy_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == ST_ROUND && rnd_q != CNT_W'(ROUNDS)) |=> fsm_q == ST_ROUND);

    a_r9_sample_at_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == ST_IDLE && start) |=> (key_q == $past(key) && state_q == $past(plaintext)));

    a_r8_ct_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(ciphertext));

    a_r2_round_range: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q == ST_ROUND |-> (rnd_q >= CNT_W'(1) && rnd_q <= CNT_W'(ROUNDS)));

endmodule

bind spn_cipher_core spn_cipher_core_chk #(
    .BLOCK_W (BLOCK_W),
    .KEY_W   (KEY_W),
    .ROUNDS  (ROUNDS),
    .CNT_W   (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .done       (done),
    .plaintext  (plaintext),
    .key        (key),
    .ciphertext (ciphertext),
    .fsm_q      (fsm_q),
    .rnd_q      (rnd_q),
    .key_q      (key_q),
    .state_q    (state_q)
);

// File: tb/tb_spn_cipher_core.sv
module tb_spn_cipher_core;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [63:0]  pt_i = '0;
    logic [127:0] key_i = '0;
    logic [63:0]  ct_o;
    logic         done_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    spn_cipher_core dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .plaintext  (pt_i),
        .key        (key_i),
        .ciphertext (ct_o),
        .done       (done_o)
    );

    // ---------------- behavioural model built from R2..R5 ----------------
    localparam logic [63:0] SB_TABLE = 64'hC56B90AD3EF84712;

    function automatic logic [3:0] m_sbox(input logic [3:0] x);
        return SB_TABLE[(15 - int'(x))*4 +: 4];
    endfunction

    function automatic logic [63:0] m_encrypt(input logic [63:0] p, input logic [127:0] k);
        logic [63:0]  s, t;
        logic [127:0] r;
        s = p;
        r = k;
        for (int rd = 1; rd <= 31; rd++) begin
            s = s ^ r[127:64];
            for (int n = 0; n < 16; n++) t[n*4 +: 4] = m_sbox(s[n*4 +: 4]);
            s = t;
            for (int b = 0; b < 64; b++) t[(b == 63) ? 63 : (b*16) % 63] = s[b];
            s = t;
            r = {r[66:0], r[127:67]};
            r[127:124] = m_sbox(r[127:124]);
            r[123:120] = m_sbox(r[123:120]);
            r[66:62]   = r[66:62] ^ 5'(rd);
        end
        return s ^ r[127:64];
    endfunction

    // ---------------- helpers ----------------
    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic launch(input logic [63:0] p, input logic [127:0] k);
        @(negedge clk);
        start = 1'b1;
        pt_i  = p;
        key_i = k;
        @(negedge clk);
        start = 1'b0;
    endtask

    // observe 40 edges after the accept edge: first done edge and pulse count
    task automatic await_done(output int lat, output int pulses);
        lat = -1;
        pulses = 0;
        for (int c = 1; c <= 40; c++) begin
            @(negedge clk);
            if (done_o) begin
                pulses++;
                if (lat < 0) lat = c;
            end
        end
    endtask

    task automatic run_vec(input string req, input logic [63:0] p, input logic [127:0] k);
        int lat, pulses;
        logic [63:0] exp;
        exp = m_encrypt(p, k);
        launch(p, k);
        await_done(lat, pulses);
        check({req, " ciphertext"}, 128'(ct_o), 128'(exp));
        check("R6 latency", 128'(lat), 128'(32));
        check("R6 one pulse", 128'(pulses), 128'(1));
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check("R1 done in reset", 128'(done_o), 128'(0));
        check("R1 ct in reset", 128'(ct_o), 128'(0));
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", 128'(done_o), 128'(0));
        check("R1 ct after reset", 128'(ct_o), 128'(0));
    endtask

    task automatic t_corners();
        run_vec("R2 zero/zero", 64'h0, 128'h0);
        run_vec("R2 ones/zero", {64{1'b1}}, 128'h0);
        run_vec("R3 zero/ones", 64'h0, {128{1'b1}});
        run_vec("R3 ones/ones", {64{1'b1}}, {128{1'b1}});
    endtask

    task automatic t_key_low_bits();
        run_vec("R5 key bit0", 64'h0123_4567_89AB_CDEF, 128'h1);
        run_vec("R5 key bit62", 64'h0123_4567_89AB_CDEF, 128'h1 << 62);
        run_vec("R5 key bit66", 64'h0123_4567_89AB_CDEF, 128'h1 << 66);
    endtask

    task automatic t_perm_bits();
        run_vec("R4 pt bit63", 64'h8000_0000_0000_0000, 128'h0);
        run_vec("R4 pt bit1", 64'h2, 128'h0);
        run_vec("R4 pt bit17", 64'h1 << 17, 128'h0);
    endtask

    task automatic t_random();
        logic [63:0] x = 64'h9E37_79B9_7F4A_7C15;
        for (int i = 0; i < 6; i++) begin
            logic [63:0]  p;
            logic [127:0] k;
            x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
            p = x;
            x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
            k[127:64] = x;
            x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
            k[63:0] = x;
            run_vec("R3 random", p, k);
        end
    endtask

    task automatic t_busy_start();
        logic [63:0]  pa = 64'hDEAD_BEEF_0BAD_F00D;
        logic [127:0] ka = 128'h0F0E_0D0C_0B0A_0908_0706_0504_0302_0100;
        int lat = -1;
        int pulses = 0;
        launch(pa, ka);
        for (int c = 1; c <= 70; c++) begin
            @(negedge clk);
            if (done_o) begin
                pulses++;
                if (lat < 0) lat = c;
            end
            if (c == 10 || c == 31) begin
                start = 1'b1;
                pt_i  = ~pa;
                key_i = ~ka;
            end else begin
                start = 1'b0;
            end
        end
        check("R7 result of first block", 128'(ct_o), 128'(m_encrypt(pa, ka)));
        check("R7 latency unchanged", 128'(lat), 128'(32));
        check("R7 no extra done", 128'(pulses), 128'(1));
    endtask

    task automatic t_back_to_back();
        logic [63:0]  pa = 64'h1111_2222_3333_4444;
        logic [63:0]  pb = 64'hAAAA_5555_CCCC_3333;
        logic [127:0] kb = 128'h5A5A_0000_FFFF_1234_8765_4321_0F0F_F0F0;
        int lat_b = -1;
        launch(pa, 128'h0);
        for (int c = 1; c <= 70; c++) begin
            @(negedge clk);
            if (c == 32) begin
                check("R6 first done", 128'(done_o), 128'(1));
                check("R2 first of pair", 128'(ct_o), 128'(m_encrypt(pa, 128'h0)));
                start = 1'b1;
                pt_i  = pb;
                key_i = kb;
            end else begin
                start = 1'b0;
            end
            if (c > 32 && done_o && lat_b < 0) lat_b = c;
        end
        check("R6 back-to-back latency", 128'(lat_b), 128'(65));
        check("R2 second of pair", 128'(ct_o), 128'(m_encrypt(pb, kb)));
    endtask

    task automatic t_input_change();
        logic [63:0]  pa = 64'hFEDC_BA98_7654_3210;
        logic [127:0] ka = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        int lat, pulses;
        launch(pa, ka);
        pt_i  = 64'h0;
        key_i = {128{1'b1}};
        await_done(lat, pulses);
        check("R9 inputs changed mid-run", 128'(ct_o), 128'(m_encrypt(pa, ka)));
    endtask

    task automatic t_hold();
        logic [63:0] held;
        int seen = 0;
        held = ct_o;
        pt_i  = 64'h1234;
        key_i = 128'h5678;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (done_o || ct_o !== held) seen++;
        end
        check("R8 ct held while idle", 128'(ct_o), 128'(held));
        check("R8 no change events", 128'(seen), 128'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_corners();
        t_key_low_bits();
        t_perm_bits();
        t_random();
        t_busy_start();
        t_back_to_back();
        t_input_change();
        t_hold();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule